// File: doc/BRIEF.md
# Delay-Tap Sweep Calibration Engine

This engine finds a working pair of clock-delay settings for an external memory interface. One setting delays the clock that captures read data. The other shifts the phase of the clock sent to the memory. Neither setting can be predicted from the board, so the engine tries all of them. It steps through every combination of the two tap values. At each combination it waits for the delay lines to settle, then runs a fixed number of write/read-back checks through a simple request/response memory port. The point is marked good only if every check returned the data that was written.

When the sweep is over, the engine forms a candidate operating point from the rounded centroid of all good points. It then confirms that a square window of half-width `MARGIN` around that candidate lies inside the tap range and holds only good points. If that holds, the candidate appears on the tap outputs and the status reports success. Otherwise the taps return to zero and the fail flag is raised.

The tap width, repetition count, margin and data/address widths are parameters. Production use sets `TAP_W` = 8, `REPS` = 10000 and `MARGIN` = 25. The default width is smaller so that the pass map stays a few thousand bits when the block is elaborated with its defaults.

Top module: `tapcal_engine`

## Requirements
- R1: After reset, busy, done and fail are low, both tap outputs are zero and no memory request is valid.
- R2: A start pulse seen while idle begins a sweep. Busy stays high until a single-cycle done pulse, which comes with busy low. A start pulse while busy has no effect on the sweep in progress, and no request is valid while idle.
- R3: The sweep visits every (read tap, output tap) pair exactly once. The read tap is the outer loop and the output tap the inner one, both counting up from 0, so the linear index {read, output} rises by one at each step. While busy, the tap outputs show the pair under test.
- R4: After every tap change, including the first pair, no memory request is issued for at least `settle_cycles_i` cycles.
- R5: Each pair gets exactly `REPS` checks. A check is a write (`mem_req_write_o` = 1) followed by a read (`mem_req_write_o` = 0) of the same address, and the address is the repetition index. Each request waits for its response before the next request is issued. A request holds address, data and direction stable until accepted.
- R6: A pair is good only if all `REPS` read responses equal the word written. A mismatch in any single repetition, including the last, marks the pair bad. The internal mismatch count saturates rather than wrapping.
- R7: On each axis, the candidate is floor((S + N/2) / N). S is the sum of that axis's coordinates over all good pairs and N is the number of good pairs.
- R8: Calibration succeeds only if candidate − `MARGIN` ≥ 0 and candidate + `MARGIN` ≤ 2^`TAP_W` − 1 on both axes, and every pair in the (2·`MARGIN`+1)² window centred on the candidate is good.
- R9: If no pair is good, calibration fails.
- R10: At done, fail reports the outcome. The tap outputs hold the candidate after success, or zero after failure, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse to begin a calibration sweep |
| settle_cycles_i | input | 16 | Idle cycles to wait after each tap change |
| busy_o | output | 1 | High while a calibration is in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| fail_o | output | 1 | Calibration found no acceptable operating point |
| rd_tap_o | output | TAP_W | Read-capture clock delay tap |
| out_tap_o | output | TAP_W | Memory output clock delay tap |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | ADDR_W | Request address |
| mem_req_wdata_o | output | DATA_W | Write data |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_ready_o | output | 1 | Engine accepts the response |
| mem_rsp_rdata_i | input | DATA_W | Read response data |

## Verification
Two functions of this block can land on the same point: the bad data of a single repetition, and the closing of that point's classification. The sharpest case is a mismatch on only the last read of a pair, because the tally must still include it when the point is recorded.

The bench provokes this by corrupting only the final read at one pair inside an otherwise good region. It judges the result by the calibration outcome. The hole sits inside the margin window, so the run must end in failure rather than at the centroid the good region would otherwise give.

The bench also feeds random ready and response delays. It injects a second start pulse in the middle of a sweep and checks that the visiting order stays unbroken.

// File: rtl/tapcal_pkg.sv
// Shared types for the delay-tap calibration engine.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tapcal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_WR_REQ,
        ST_WR_RSP,
        ST_RD_REQ,
        ST_RD_RSP,
        ST_POINT,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_BOUND,
        ST_SCAN,
        ST_FINISH
    } cal_state_e;

endpackage

// File: rtl/tapcal_lfsr.sv
// Galois LFSR that produces the test data words.
// Loads a fixed non-zero seed on load_i and steps once per adv_i.
// Assumes POLY is a maximal-length tap mask for width W.
module tapcal_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'hACE1_2B5D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         adv_i,
    output logic [W-1:0] val_o
);

    logic [W-1:0] state_q;

    // Load the seed or advance one Galois step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (load_i) begin
            state_q <= SEED;
        end else if (adv_i) begin
            state_q <= state_q[0] ? ((state_q >> 1) ^ POLY) : (state_q >> 1);
        end
    end

    assign val_o = state_q;

endmodule

// File: rtl/tapcal_passmap.sv
// Single-bit pass/fail map with one pair of coordinates per entry.
// Synchronous write, combinational read. Every entry is written during a
// sweep before it is read, so the array needs no reset.
module tapcal_passmap #(
    parameter int IDX_W = 12,
    localparam int NPTS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_bit_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_bit_o
);

    logic map_q [NPTS];

    // Record the classification of one point.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            map_q[wr_idx_i] <= wr_bit_i;
        end
    end

    assign rd_bit_o = map_q[rd_idx_i];

endmodule

// File: rtl/tapcal_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
// start_i loads the operands. done_o pulses W cycles later with the
// low QW bits of the quotient. Assumes den_i is non-zero and held
// stable while the division runs.
module tapcal_div #(
    parameter int W  = 19,
    parameter int QW = 6,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  num_i,
    input  logic [W-1:0]  den_i,
    output logic          done_o,
    output logic [QW-1:0] quo_o
);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    rem_sh;
    logic          fits;
    logic [W-1:0]  rem_nx;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        fits   = rem_sh >= {1'b0, den_i};
        rem_nx = fits ? W'(rem_sh - {1'b0, den_i}) : rem_sh[W-1:0];
    end

    // Shift, subtract and count down the quotient bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_q <= '0;
                quo_q <= num_i;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_nx;
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q[QW-1:0];

endmodule

// File: rtl/tapcal_engine.sv
// Delay-tap sweep calibration engine (top).
// Sweeps the read-capture tap (outer loop) and the output-clock tap
// (inner loop) over every value. At each pair it waits settle_cycles_i
// cycles, then runs REPS write/read-back checks through the memory port,
// and records a pass bit per pair. It then takes the rounded centroid of
// the passing pairs and accepts it only if a +/-MARGIN window around it
// is in range and fully passing.
// Assumes MARGIN < 2**TAP_W and the memory answers every request once.
module tapcal_engine #(
    parameter int TAP_W  = 6,
    parameter int REPS   = 10000,
    parameter int MARGIN = 25,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       settle_cycles_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [TAP_W-1:0]  rd_tap_o,
    output logic [TAP_W-1:0]  out_tap_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic              mem_req_write_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic [DATA_W-1:0] mem_req_wdata_o,
    input  logic              mem_rsp_valid_i,
    output logic              mem_rsp_ready_o,
    input  logic [DATA_W-1:0] mem_rsp_rdata_i
);

    import tapcal_pkg::*;

    localparam int IDX_W = 2 * TAP_W;
    localparam int CNT_W = IDX_W + 1;
    localparam int SUM_W = 3 * TAP_W + 1;
    localparam int REP_W = $clog2(REPS + 1);
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
    localparam logic [TAP_W-1:0] MARG_T  = TAP_W'(MARGIN);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPS - 1);

    cal_state_e        state_q;
    logic [TAP_W-1:0]  tap_rd_q, tap_out_q;
    logic [15:0]       settle_q;
    logic [REP_W-1:0]  rep_q;
    logic [15:0]       err_cnt;
    logic [SUM_W-1:0]  sum_rd_q, sum_out_q;
    logic [CNT_W-1:0]  pass_cnt_q;
    logic [TAP_W-1:0]  cand_rd_q, cand_out_q;
    logic [TAP_W-1:0]  scan_rd_q, scan_out_q;
    logic              res_fail_q;

    logic              rsp_take, mismatch, map_bit;
    logic [DATA_W-1:0] lfsr_val;
    logic [SUM_W-1:0]  num_rd, num_out, den;
    logic              div_done, div_done_out;
    logic [TAP_W-1:0]  quo_rd, quo_out;
    logic              rd_bound_ok, out_bound_ok;

    // Handshake and compare terms shared by the datapath.
    always_comb begin
        rsp_take = mem_rsp_valid_i && (state_q == ST_RD_RSP);
        mismatch = rsp_take && (mem_rsp_rdata_i != lfsr_val);
        num_rd   = sum_rd_q  + SUM_W'(pass_cnt_q >> 1);
        num_out  = sum_out_q + SUM_W'(pass_cnt_q >> 1);
        den      = SUM_W'(pass_cnt_q);
        rd_bound_ok  = (int'(cand_rd_q)  >= MARGIN) && (int'(cand_rd_q)  <= int'(TAP_MAX) - MARGIN);
        out_bound_ok = (int'(cand_out_q) >= MARGIN) && (int'(cand_out_q) <= int'(TAP_MAX) - MARGIN);
    end

    // Memory port driven straight from the state.
    always_comb begin
        mem_req_valid_o = (state_q == ST_WR_REQ) || (state_q == ST_RD_REQ);
        mem_req_write_o = (state_q == ST_WR_REQ);
        mem_req_addr_o  = ADDR_W'(rep_q);
        mem_req_wdata_o = lfsr_val;
        mem_rsp_ready_o = (state_q == ST_WR_RSP) || (state_q == ST_RD_RSP);
    end

    assign rd_tap_o  = tap_rd_q;
    assign out_tap_o = tap_out_q;

    tapcal_lfsr #(.W(DATA_W)) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (state_q == ST_IDLE && start_i),
        .adv_i  (rsp_take),
        .val_o  (lfsr_val)
    );

    tapcal_passmap #(.IDX_W(IDX_W)) u_map (
        .clk      (clk),
        .wr_en_i  (state_q == ST_POINT),
        .wr_idx_i ({tap_rd_q, tap_out_q}),
        .wr_bit_i (err_cnt == 16'd0),
        .rd_idx_i ({scan_rd_q, scan_out_q}),
        .rd_bit_o (map_bit)
    );

    tapcal_div #(.W(SUM_W), .QW(TAP_W)) u_div_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (state_q == ST_DIV_GO && pass_cnt_q != '0),
        .num_i   (num_rd),
        .den_i   (den),
        .done_o  (div_done),
        .quo_o   (quo_rd)
    );

    tapcal_div #(.W(SUM_W), .QW(TAP_W)) u_div_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (state_q == ST_DIV_GO && pass_cnt_q != '0),
        .num_i   (num_out),
        .den_i   (den),
        .done_o  (div_done_out),
        .quo_o   (quo_out)
    );

    // Sweep, classify, locate and verify the operating point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tap_rd_q   <= '0;
            tap_out_q  <= '0;
            settle_q   <= '0;
            rep_q      <= '0;
            err_cnt    <= '0;
            sum_rd_q   <= '0;
            sum_out_q  <= '0;
            pass_cnt_q <= '0;
            cand_rd_q  <= '0;
            cand_out_q <= '0;
            scan_rd_q  <= '0;
            scan_out_q <= '0;
            res_fail_q <= 1'b0;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
            fail_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        busy_o     <= 1'b1;
                        fail_o     <= 1'b0;
                        tap_rd_q   <= '0;
                        tap_out_q  <= '0;
                        settle_q   <= settle_cycles_i;
                        sum_rd_q   <= '0;
                        sum_out_q  <= '0;
                        pass_cnt_q <= '0;
                        state_q    <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_q == 16'd0) begin
                        rep_q   <= '0;
                        err_cnt <= '0;
                        state_q <= ST_WR_REQ;
                    end else begin
                        settle_q <= settle_q - 16'd1;
                    end
                end
                ST_WR_REQ: if (mem_req_ready_i) state_q <= ST_WR_RSP;
                ST_WR_RSP: if (mem_rsp_valid_i) state_q <= ST_RD_REQ;
                ST_RD_REQ: if (mem_req_ready_i) state_q <= ST_RD_RSP;
                ST_RD_RSP: begin
                    if (rsp_take) begin
                        if (mismatch && err_cnt != 16'hFFFF) err_cnt <= err_cnt + 16'd1;
                        if (rep_q == REP_LAST) begin
                            state_q <= ST_POINT;
                        end else begin
                            rep_q   <= rep_q + 1'b1;
                            state_q <= ST_WR_REQ;
                        end
                    end
                end
                ST_POINT: begin
                    if (err_cnt == 16'd0) begin
                        sum_rd_q   <= sum_rd_q  + SUM_W'(tap_rd_q);
                        sum_out_q  <= sum_out_q + SUM_W'(tap_out_q);
                        pass_cnt_q <= pass_cnt_q + 1'b1;
                    end
                    settle_q <= settle_cycles_i;
                    if (tap_out_q != TAP_MAX) begin
                        tap_out_q <= tap_out_q + 1'b1;
                        state_q   <= ST_SETTLE;
                    end else if (tap_rd_q != TAP_MAX) begin
                        tap_out_q <= '0;
                        tap_rd_q  <= tap_rd_q + 1'b1;
                        state_q   <= ST_SETTLE;
                    end else begin
                        state_q <= ST_DIV_GO;
                    end
                end
                ST_DIV_GO: begin
                    if (pass_cnt_q == '0) begin
                        res_fail_q <= 1'b1;
                        state_q    <= ST_FINISH;
                    end else begin
                        state_q <= ST_DIV_WAIT;
                    end
                end
                ST_DIV_WAIT: begin
                    if (div_done && div_done_out) begin
                        cand_rd_q  <= quo_rd;
                        cand_out_q <= quo_out;
                        state_q    <= ST_BOUND;
                    end
                end
                ST_BOUND: begin
                    if (!rd_bound_ok || !out_bound_ok) begin
                        res_fail_q <= 1'b1;
                        state_q    <= ST_FINISH;
                    end else begin
                        scan_rd_q  <= cand_rd_q  - MARG_T;
                        scan_out_q <= cand_out_q - MARG_T;
                        state_q    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (!map_bit) begin
                        res_fail_q <= 1'b1;
                        state_q    <= ST_FINISH;
                    end else if (scan_out_q != cand_out_q + MARG_T) begin
                        scan_out_q <= scan_out_q + 1'b1;
                    end else if (scan_rd_q != cand_rd_q + MARG_T) begin
                        scan_rd_q  <= scan_rd_q + 1'b1;
                        scan_out_q <= cand_out_q - MARG_T;
                    end else begin
                        res_fail_q <= 1'b0;
                        state_q    <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    busy_o     <= 1'b0;
                    done_o     <= 1'b1;
                    fail_o     <= res_fail_q;
                    tap_rd_q   <= res_fail_q ? '0 : cand_rd_q;
                    tap_out_q  <= res_fail_q ? '0 : cand_out_q;
                    res_fail_q <= 1'b0;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tapcal_checker.sv
// Temporal checks on the calibration engine, bound to every instance.
// Assumes the engine's parameters are passed through unchanged.
module tapcal_checker #(
    parameter int TAP_W  = 6,
    parameter int MARGIN = 25,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o,
    input logic [TAP_W-1:0]  rd_tap_o,
    input logic [TAP_W-1:0]  out_tap_o,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic              mem_req_write_o,
    input logic [ADDR_W-1:0] mem_req_addr_o,
    input logic [DATA_W-1:0] mem_req_wdata_o,
    input logic [15:0]       err_cnt
);

    localparam int TAP_TOP = (1 << TAP_W) - 1;

    logic past_ok;

    // Marks that at least one clock has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_valid_o);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o ##1 !done_o);

    assert_settle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (busy_o && (rd_tap_o != $past(rd_tap_o) || out_tap_o != $past(out_tap_o)))
        |-> !mem_req_valid_o);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=>
        (mem_req_valid_o && $stable(mem_req_write_o) && $stable(mem_req_addr_o)
         && $stable(mem_req_wdata_o)));

    assert_err_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != 16'd0) |=> (err_cnt >= $past(err_cnt) || err_cnt == 16'd0));

    assert_margin_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |->
        (int'(rd_tap_o) >= MARGIN && int'(rd_tap_o) <= TAP_TOP - MARGIN));

    assert_margin_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |->
        (int'(out_tap_o) >= MARGIN && int'(out_tap_o) <= TAP_TOP - MARGIN));

    assert_fail_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> (rd_tap_o == '0 && out_tap_o == '0));

endmodule

bind tapcal_engine tapcal_checker #(
    .TAP_W (TAP_W),
    .MARGIN(MARGIN),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .fail_o          (fail_o),
    .rd_tap_o        (rd_tap_o),
    .out_tap_o       (out_tap_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_write_o (mem_req_write_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_wdata_o (mem_req_wdata_o),
    .err_cnt         (err_cnt)
);

// File: tb/tb_tapcal_engine.sv
// Bench for tapcal_engine: a memory model corrupts reads at tap pairs
// outside a chosen good region. Expected outcomes come from bench functions.
module tb_tapcal_engine;

    localparam int CLK_PERIOD = 10;
    localparam int TAP_W  = 4;
    localparam int REPS   = 3;
    localparam int MARGIN = 2;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int TMAX   = (1 << TAP_W) - 1;
    localparam int NPTS   = 1 << (2 * TAP_W);
    localparam int RUN_LIMIT = 30000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [15:0]       settle_cycles_i = 16'd0;
    logic              busy_o, done_o, fail_o;
    logic [TAP_W-1:0]  rd_tap_o, out_tap_o;
    logic              mem_req_valid_o, mem_req_write_o, mem_rsp_ready_o;
    logic              mem_req_ready_i = 1'b0;
    logic              mem_rsp_valid_i = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr_o;
    logic [DATA_W-1:0] mem_req_wdata_o;
    logic [DATA_W-1:0] mem_rsp_rdata_i = '0;

    tapcal_engine #(
        .TAP_W(TAP_W), .REPS(REPS), .MARGIN(MARGIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_cycles_i(settle_cycles_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .rd_tap_o(rd_tap_o), .out_tap_o(out_tap_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_req_wdata_o(mem_req_wdata_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_ready_o(mem_rsp_ready_o), .mem_rsp_rdata_i(mem_rsp_rdata_i)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit hung     = 1'b0;

    // Good region description used by both the model and the predictor.
    int g_r0, g_r1, g_o0, g_o1;
    bit g_hole;
    int g_hr, g_ho;

    // Monitor and model state.
    int  prev_idx, since, reads_here, points, ord_err, set_err, r5_err, settle_now;
    bit  busy_prev, first_req, wr_seen;
    int  last_wr_addr;
    bit  acc_prev, acc_wr, cons_prev, pend;
    int  acc_addr, delay;
    logic [DATA_W-1:0] acc_data, pend_data;
    logic [DATA_W-1:0] mem_arr [1 << ADDR_W];

    function automatic bit in_rect(int r, int o);
        return r >= g_r0 && r <= g_r1 && o >= g_o0 && o <= g_o1;
    endfunction

    function automatic bit good_pt(int r, int o);
        return in_rect(r, o) && !(g_hole && r == g_hr && o == g_ho);
    endfunction

    // Predicted outcome from R6..R10.
    function automatic void predict(output bit e_fail, output int e_r, output int e_o);
        int sr = 0, so = 0, cnt = 0;
        e_fail = 1'b0; e_r = 0; e_o = 0;
        for (int r = 0; r <= TMAX; r++)
            for (int o = 0; o <= TMAX; o++)
                if (good_pt(r, o)) begin sr += r; so += o; cnt++; end
        if (cnt == 0) begin e_fail = 1'b1; return; end
        e_r = (sr + cnt / 2) / cnt;
        e_o = (so + cnt / 2) / cnt;
        if (e_r < MARGIN || e_r > TMAX - MARGIN || e_o < MARGIN || e_o > TMAX - MARGIN)
            e_fail = 1'b1;
        else
            for (int r = e_r - MARGIN; r <= e_r + MARGIN; r++)
                for (int o = e_o - MARGIN; o <= e_o + MARGIN; o++)
                    if (!good_pt(r, o)) e_fail = 1'b1;
        if (e_fail) begin e_r = 0; e_o = 0; end
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Memory model and protocol monitor, all at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ready_i = 1'b0; mem_rsp_valid_i = 1'b0;
            acc_prev = 0; cons_prev = 0; pend = 0; busy_prev = 0; prev_idx = 0;
        end else begin
            int cur;
            cur = {rd_tap_o, out_tap_o};
            if (busy_o && !busy_prev) begin
                if (cur != 0) ord_err++;
                points = 1; since = 0; reads_here = 0; first_req = 1; wr_seen = 0;
            end else if (busy_o && cur != prev_idx) begin
                if (cur != prev_idx + 1) ord_err++;
                if (reads_here != REPS) r5_err++;
                points++; since = 0; reads_here = 0; first_req = 1; wr_seen = 0;
            end else begin
                since++;
            end
            if (busy_o && mem_req_valid_o && first_req) begin
                if (since < settle_now) set_err++;
                first_req = 0;
            end
            prev_idx  = cur;
            busy_prev = busy_o;

            if (acc_prev) begin
                if (acc_wr) begin
                    mem_arr[acc_addr] = acc_data;
                    pend_data = '0;
                    last_wr_addr = acc_addr; wr_seen = 1;
                end else begin
                    bit bad;
                    if (!wr_seen || acc_addr != last_wr_addr || acc_addr != reads_here) r5_err++;
                    wr_seen = 0;
                    bad = !in_rect(rd_tap_o, out_tap_o) ||
                          (g_hole && rd_tap_o == g_hr && out_tap_o == g_ho && reads_here == REPS - 1);
                    pend_data = mem_arr[acc_addr] ^ (bad ? 32'h1 : 32'h0);
                    reads_here++;
                end
                pend = 1; delay = $urandom % 2;
            end
            if (cons_prev) begin mem_rsp_valid_i = 1'b0; pend = 0; end
            if (pend && !mem_rsp_valid_i) begin
                if (delay == 0) begin mem_rsp_valid_i = 1'b1; mem_rsp_rdata_i = pend_data; end
                else delay--;
            end
            mem_req_ready_i = !pend && ($urandom % 3 != 0);
            acc_prev = mem_req_valid_o && mem_req_ready_i;
            acc_wr   = mem_req_write_o;
            acc_addr = mem_req_addr_o;
            acc_data = mem_req_wdata_o;
            cons_prev = mem_rsp_valid_i && mem_rsp_ready_o;
        end
    end

    task automatic run_case(string tag, int r0, int r1, int o0, int o1,
                            bit hole, int hr, int ho, int settle, bit restart_mid);
        bit e_fail, got;
        int e_r, e_o;
        if (hung) return;
        g_r0 = r0; g_r1 = r1; g_o0 = o0; g_o1 = o1; g_hole = hole; g_hr = hr; g_ho = ho;
        predict(e_fail, e_r, e_o);
        ord_err = 0; set_err = 0; r5_err = 0; points = 0;
        settle_now = settle; settle_cycles_i = 16'(settle);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        if (restart_mid) begin
            repeat (400) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        end
        got = 0;
        for (int c = 0; c < RUN_LIMIT && !got; c++) begin
            @(negedge clk);
            if (done_o) got = 1;
        end
        check(got, "R2", "done pulse seen", got, 1);
        if (!got) begin hung = 1; return; end
        check(fail_o == e_fail, tag, "fail flag", fail_o, e_fail);
        check(rd_tap_o == e_r, tag, "read tap", rd_tap_o, e_r);
        check(out_tap_o == e_o, tag, "output tap", out_tap_o, e_o);
        check(fail_o == e_fail && rd_tap_o == e_r && out_tap_o == e_o, "R10", "result at done", fail_o, e_fail);
        check(ord_err == 0 && points == NPTS, "R3", "sweep order/points", points, NPTS);
        check(set_err == 0, "R4", "settle violations", set_err, 0);
        check(r5_err == 0, "R5", "write/read protocol errors", r5_err, 0);
        @(negedge clk);
        check(!done_o && !busy_o, "R2", "done single cycle", done_o, 0);
        check(rd_tap_o == e_r && out_tap_o == e_o, "R10", "taps held", rd_tap_o, e_r);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !fail_o, "R1", "status after reset", busy_o, 0);
        check(rd_tap_o == 0 && out_tap_o == 0, "R1", "taps after reset", rd_tap_o, 0);
        check(!mem_req_valid_o, "R1", "no request after reset", mem_req_valid_o, 0);

        run_case("R7", 1, 14, 1, 14, 0, 0, 0, 2, 0);   // centroid 7.5 rounds to 8
        run_case("R7", 0, TMAX, 0, TMAX, 0, 0, 0, 0, 0); // everything good
        run_case("R7", 4, 9, 6, 13, 0, 0, 0, 3, 0);    // asymmetric: (7,10)
        run_case("R8", 3, 5, 3, 5, 0, 0, 0, 1, 0);     // window leaves region
        run_case("R9", 1, 0, 0, TMAX, 0, 0, 0, 1, 0);  // nothing good
        run_case("R6", 1, 14, 1, 14, 1, 8, 9, 2, 0);   // last-rep error in window
        run_case("R8", 0, 4, 0, TMAX, 0, 0, 0, 1, 0);  // candidate exactly at margin
        run_case("R8", 0, 2, 0, TMAX, 0, 0, 0, 1, 0);  // candidate below margin
        run_case("R2", 1, 14, 1, 14, 0, 0, 0, 2, 1);   // second start mid-sweep ignored
        for (int k = 0; k < 3; k++) begin
            int a, b, c, d;
            a = $urandom % 8; b = a + $urandom % (TMAX + 1 - a);
            c = $urandom % 8; d = c + $urandom % (TMAX + 1 - c);
            run_case("R8", a, b, c, d, ($urandom % 2) == 1,
                     $urandom % (TMAX + 1), $urandom % (TMAX + 1), $urandom % 4, 0);
        end
        if (hung) $display("FAIL R2 watchdog expired: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule